// File: doc/BRIEF.md
# Flow-through zero-turnaround synchronous SRAM

This block is a single-clock synchronous memory with one shared data path whose inputs are all registered on the rising clock edge. It allows a read and a write to follow each other on consecutive cycles with no idle cycle between them. A read returns its data in the same cycle in which its address was registered, so the data flows through. A write takes its data and byte selects one edge after its address, and that same edge may start the next operation.

Each word is made of four lanes. A lane holds an 8-bit byte plus one parity bit, and each lane has its own active-low write select. A two-bit burst counter steps through the low two address bits, in either linear or interleaved order, for up to four accesses per loaded address. A clock-enable input freezes the whole block. A sleep input, which may arrive at any time, is brought into the clock domain and blocks new accesses while the block sleeps and while it wakes. The shared bus is split into a data-in port, a data-out port and a drive flag. The port is a plain pin-level memory interface with no valid/ready handshake: every enabled edge is accepted, and the block never applies back-pressure.

Top module: `zbt_ft_sram`

## Requirements
- R1: While `cen_n` is high, no clock edge changes the current access, the burst step or the memory contents. The cycle in progress simply lasts longer.
- R2: A read begins on an edge with `cen_n` low, the block selected (`sel1_n`=0, `sel2`=1, `sel3_n`=0), `wr_n`=1 and `adv_ld`=0. From that edge on, `dout` shows the word at the registered address, and `dout_en` is 1 if `oe_n` is low.
- R3: A write begins on an edge with `cen_n` low, the block selected, `wr_n`=0 and `adv_ld`=0. The next enabled edge stores `din` at the write address. That same edge may begin a new read or write.
- R4: An enabled edge with `adv_ld`=1 steps the burst counter and ignores the three selects and `wr_n`. The read or write type fixed at load time holds for the whole burst. An advance edge while no access is current leaves the block idle with the bus undriven.
- R5: The order is taken from `mode` at load time, and later changes of `mode` do not affect the burst. With the order bit at 0, access k of a burst uses low address bits (start+k) mod 4. With the order bit at 1, it uses start XOR k. The upper address bits never change during a burst.
- R6: Lane k is bits [9k+8:9k] of the word, and bit 9k+8 is its parity. The lane is written only when `bws_n[k]`=0. A lane whose select is 1 keeps its previous contents, so a write with `bws_n`=4'b1111 changes nothing.
- R7: `dout_en` is 0 in three cases, whatever `oe_n` does: during a write's data cycle, while the block is deselected, and in the idle cycle after a deselect. Otherwise it follows `oe_n` low.
- R8: After reset no access is current and `dout_en` is 0.
- R9: `sleep` passes through two synchronising flops. From the time the synchronised level is high until two cycles after it falls, enabled edges end any current access, start no new one, and store no data. During that time `dout_en` is 0. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| wr_n | input | 1 | Write enable, active low, sampled at load |
| adv_ld | input | 1 | 1 advances the burst, 0 loads an address |
| bws_n | input | 4 | Per-lane write selects, active low |
| mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Asynchronous sleep request |
| addr | input | 6 | Word address |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Read data, flow-through |
| dout_en | output | 1 | High when the block drives the bus |

## Verification
The bench uses the default parameters: a 64-word array of four 9-bit lanes and a two-cycle wake time. With 64 words, the whole array can be filled with back-to-back bursts, so the behavioural model can predict every read, including random ones. Several bursts start at non-zero offsets, so both orders wrap within their block of four. The short wake window lets the bench probe the sleep entry edge, the sleep exit edge and the recovery cycles one by one.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_order_e;

  function automatic logic [1:0] burst_index(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input burst_order_e order);
    if (order == ORD_INTERLEAVE) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/zbt_sleep_sync.sv
module zbt_sleep_sync #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic blocked
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic         s1_q, s2_q;
  logic [CW-1:0] wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      wake_q <= '0;
    end else begin
      s1_q <= sleep;
      s2_q <= s1_q;
      if (s2_q) wake_q <= CW'(WAKE_CYC);
      else if (wake_q != '0) wake_q <= wake_q - 1'b1;
    end
  end

  assign blocked = s2_q || (wake_q != '0);
endmodule

// File: rtl/zbt_access_ctrl.sv
module zbt_access_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              adv_ld,
  input  logic              mode,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] addr,
  output logic              cur_valid,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_fire
);
  logic [ADDR_W-3:0] hi_q;
  logic [1:0]        start_q, step_q;
  burst_order_e      order_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_write <= 1'b0;
      hi_q      <= '0;
      start_q   <= '0;
      step_q    <= '0;
      order_q   <= ORD_LINEAR;
    end else if (!cen_n) begin
      if (blocked) begin
        cur_valid <= 1'b0;
      end else if (!adv_ld) begin
        if (sel) begin
          cur_valid <= 1'b1;
          cur_write <= ~wr_n;
          hi_q      <= addr[ADDR_W-1:2];
          start_q   <= addr[1:0];
          step_q    <= '0;
          order_q   <= burst_order_e'(mode);
        end else begin
          cur_valid <= 1'b0;
        end
      end else if (cur_valid) begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assign cur_addr = {hi_q, burst_index(start_q, step_q, order_q)};
  assign wr_fire  = !cen_n && !blocked && cur_valid && cur_write;
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_fire,
  input  logic [LANES-1:0]        bws_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_fire && !bws_n[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[addr];
  end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int BYTE_W   = 8,
  parameter int WAKE_CYC = 2,
  localparam int LANE_W  = BYTE_W + 1,
  localparam int WORD_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic              adv_ld,
  input  logic [LANES-1:0]  bws_n,
  input  logic              mode,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);
  logic              blocked;
  logic              sel;
  logic              cur_valid, cur_write, wr_fire;
  logic [ADDR_W-1:0] cur_addr;

  assign sel = !sel1_n && sel2 && !sel3_n;

  zbt_sleep_sync #(.WAKE_CYC(WAKE_CYC)) sleep_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .blocked(blocked)
  );

  zbt_access_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel(sel), .wr_n(wr_n),
    .adv_ld(adv_ld), .mode(mode), .blocked(blocked), .addr(addr),
    .cur_valid(cur_valid), .cur_write(cur_write), .cur_addr(cur_addr),
    .wr_fire(wr_fire)
  );

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .wr_fire(wr_fire), .bws_n(bws_n), .addr(cur_addr),
    .wdata(din), .rdata(dout)
  );

  assign dout_en = cur_valid && !cur_write && !oe_n && !blocked;
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cen_n,
  input logic              adv_ld,
  input logic              oe_n,
  input logic              dout_en,
  input logic              blocked,
  input logic              cur_valid,
  input logic              cur_write,
  input logic [ADDR_W-1:0] cur_addr
);
  // R1: a suspended edge leaves the current access untouched
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cen_n)) |->
      ($stable(cur_valid) && $stable(cur_write) && $stable(cur_addr)));

  // R4: an advance keeps the access type and validity
  p_burst_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cen_n && adv_ld && !blocked)) |->
      (cur_write == $past(cur_write) && cur_valid == $past(cur_valid)));

  // R7: no drive during a write data cycle
  p_wdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && cur_write) |-> !dout_en);

  // R7: no drive when output enable is high
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R7: no drive while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |-> !dout_en);

  // R8: bus released during reset
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> !dout_en);

  // R9: no drive while asleep or waking
  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !dout_en);
endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld), .oe_n(oe_n),
  .dout_en(dout_en), .blocked(blocked), .cur_valid(cur_valid),
  .cur_write(cur_write), .cur_addr(cur_addr)
);

// File: tb/zbt_ft_sram_tb.sv
`timescale 1ns/1ps
module zbt_ft_sram_tb_top;
  localparam int AW = 6;
  localparam int WW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic wr_n = 1'b1, adv_ld = 1'b0, mode = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]    bws_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] din = '0;
  logic [WW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  zbt_ft_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .wr_n(wr_n), .adv_ld(adv_ld), .bws_n(bws_n),
    .mode(mode), .oe_n(oe_n), .sleep(sleep), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  // behavioural reference
  logic [WW-1:0] mm [64];
  bit m_act, m_wr, m_ilv;
  int m_hi, m_start, m_step;
  bit m_s1, m_s2;
  int m_wake;

  function automatic int m_addr();
    int lo;
    lo = m_ilv ? (m_start ^ m_step) : ((m_start + m_step) % 4);
    return m_hi * 4 + lo;
  endfunction

  function automatic bit m_blocked();
    return m_s2 || (m_wake != 0);
  endfunction

  task automatic m_edge();
    bit blk;
    bit selected;
    blk = m_blocked();
    selected = !sel1_n && sel2 && !sel3_n;
    if (!cen_n) begin
      if (blk) m_act = 0;
      else begin
        if (m_act && m_wr)
          for (int k = 0; k < 4; k++)
            if (!bws_n[k]) mm[m_addr()][k*9 +: 9] = din[k*9 +: 9];
        if (!adv_ld) begin
          if (selected) begin
            m_act = 1; m_wr = !wr_n; m_hi = addr / 4; m_start = addr % 4;
            m_step = 0; m_ilv = mode;
          end else m_act = 0;
        end else if (m_act) m_step = (m_step + 1) % 4;
      end
    end
    if (m_s2) m_wake = 2; else if (m_wake != 0) m_wake--;
    m_s2 = m_s1;
    m_s1 = sleep;
  endtask

  task automatic check(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: compare outputs, then let the edge happen
  task automatic tick(string tag);
    bit exp_en;
    #1;
    exp_en = m_act && !m_wr && !oe_n && !m_blocked();
    check({tag, " dout_en"}, {35'd0, dout_en}, {35'd0, exp_en});
    if (exp_en) check({tag, " dout"}, dout, mm[m_addr()]);
    @(posedge clk);
    m_edge();
    @(negedge clk);
  endtask

  task automatic drive(bit c_n, bit s, bit w_n, bit adv, logic [3:0] b,
                       logic [AW-1:0] a, logic [WW-1:0] d);
    cen_n = c_n; sel1_n = !s; sel2 = s; sel3_n = !s;
    wr_n = w_n; adv_ld = adv; bws_n = b; addr = a; din = d;
  endtask

  function automatic logic [WW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_act = 0; m_wr = 0; m_ilv = 0; m_hi = 0; m_start = 0; m_step = 0;
    m_s1 = 0; m_s2 = 0; m_wake = 0;
    @(negedge clk); @(negedge clk);
    #1;
    check("R8 reset idle", {35'd0, dout_en}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    tick("R8");

    // R3: fill all words with chained linear burst writes, back to back
    mode = 0;
    for (int blk = 0; blk < 16; blk++) begin
      drive(0, 1, 0, 0, 4'h0, AW'(blk * 4), rnd_word());
      tick("R3 load");
      for (int s = 0; s < 3; s++) begin
        drive(0, 0, 1, 1, 4'h0, '0, rnd_word());
        tick("R3 burst");
      end
    end
    drive(0, 0, 1, 0, 4'h0, '0, rnd_word());
    tick("R3 last");

    // R2 / R3: write then immediate read of the same word
    drive(0, 1, 0, 0, 4'hF, 6'd20, '0); tick("R3 wr");
    drive(0, 1, 1, 0, 4'h0, 6'd20, 36'hA5A5A5A5A); tick("R2 rd after wr");
    drive(0, 0, 1, 0, 4'h0, 6'd0, '0); tick("R2 shows data");

    // R6: lane mask, and an all-masked write
    drive(0, 1, 0, 0, 4'h0, 6'd8, '0); tick("R6 wr");
    drive(0, 1, 0, 0, 4'b1010, 6'd9, 36'h123456789); tick("R6 mask");
    drive(0, 1, 1, 0, 4'b1111, 6'd8, 36'hFFFFFFFFF); tick("R6 none");
    drive(0, 1, 1, 0, 4'h0, 6'd9, '0); tick("R6 rd8");
    drive(0, 0, 1, 0, 4'h0, 6'd0, '0); tick("R6 rd9");

    // R5: linear and interleaved reads from offset 1; R4 selects/wr ignored
    for (int md = 0; md < 2; md++) begin
      mode = md[0];
      drive(0, 1, 1, 0, 4'h0, 6'd9, '0); tick("R5 load");
      mode = !md[0];
      for (int s = 0; s < 4; s++) begin
        drive(0, s[0], s[1], 1, 4'h0, 6'd0, '0); tick("R5 R4 burst");
      end
    end
    // R4: interleaved write burst ignores deselect mid-burst
    mode = 1;
    drive(0, 1, 0, 0, 4'h0, 6'd34, '0); tick("R4 wload");
    for (int s = 0; s < 3; s++) begin
      drive(0, 0, 1, 1, 4'h0, 6'd0, rnd_word()); tick("R4 wburst");
    end
    drive(0, 1, 1, 0, 4'h0, 6'd32, rnd_word()); tick("R4 wend");
    for (int s = 0; s < 3; s++) begin
      drive(0, 0, 0, 1, 4'h0, 6'd0, '0); tick("R4 rback");
    end

    // R1: suspend mid-burst, including oe toggle and a masked write attempt
    mode = 0;
    drive(0, 1, 0, 0, 4'h0, 6'd40, '0); tick("R1 wload");
    drive(1, 1, 1, 0, 4'h0, 6'd3, 36'h111111111); tick("R1 hold");
    drive(1, 0, 0, 1, 4'h0, 6'd3, 36'h222222222); tick("R1 hold");
    drive(0, 0, 1, 0, 4'h0, 6'd0, 36'h333333333); tick("R1 resume");
    drive(0, 1, 1, 0, 4'h0, 6'd40, '0); tick("R1 rload");
    oe_n = 1;
    drive(1, 1, 0, 0, 4'h0, 6'd1, '0); tick("R1 R7 oe high");
    oe_n = 0;
    drive(1, 1, 0, 0, 4'h0, 6'd1, '0); tick("R1 still");
    drive(0, 0, 1, 1, 4'h0, 6'd0, '0); tick("R1 adv");

    // R7: deselect, advance while idle
    drive(0, 0, 1, 0, 4'h0, 6'd0, '0); tick("R7 desel");
    drive(0, 1, 1, 1, 4'h0, 6'd5, '0); tick("R7 R4 idle adv");
    drive(0, 1, 1, 1, 4'h0, 6'd5, '0); tick("R7 idle adv");
    #1;
    check("R7 no drive after idle adv", {35'd0, dout_en}, 36'd0);

    // R9: sleep entry, attempts while asleep, wake
    drive(0, 1, 1, 0, 4'h0, 6'd12, '0); tick("R9 pre");
    sleep = 1;
    for (int c = 0; c < 6; c++) begin
      drive(0, 1, c[0], 0, 4'h0, AW'(c), 36'h0F0F0F0F0); tick("R9 asleep");
    end
    sleep = 0;
    for (int c = 0; c < 6; c++) begin
      drive(0, 1, 1, 0, 4'h0, AW'(c), '0); tick("R9 wake");
    end
    for (int c = 0; c < 6; c++) begin
      drive(0, 1, 1, 0, 4'h0, AW'(c), '0); tick("R9 kept");
    end

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      drive(($urandom % 8) == 0, ($urandom % 5) != 0, $urandom % 2,
            ($urandom % 3) == 0, 4'($urandom), AW'($urandom), rnd_word());
      mode = $urandom % 2;
      oe_n = ($urandom % 6) == 0;
      tick("R2 R3 R5 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule